// File: doc/BRIEF.md
# Gated Decade Frequency Counter

This block measures the rate of a digitized input signal. It counts the rising edges of that signal while a gate is open, and the gate length is an exact multiple of the reference clock period. A free-running prescaler and a chain of decade dividers produce a timing tick. The tick length is the reference clock period multiplied by the prescale factor and by a selectable power of ten.

A 4-bit state counter advances once per tick and runs through 16 states per measurement. Four of its states are decoded:

- State 0 holds the BCD counting decades at zero.
- State 2 opens the gate.
- State 12 closes the gate, so the gate stays open for exactly ten ticks.
- Entry into state 14 copies the count and an overflow flag into an output latch.

The output latch keeps the reading steady while the next measurement is under way. With the default 10 MHz reference and a prescale of 1000, range codes 0 to 5 give gates of 1 ms, 10 ms, 100 ms, 1 s, 10 s and 100 s. The reading divided by the gate time is the input frequency. With the 1 s gate and seven digits, the resolution is 1 Hz and the largest reading is 9,999,999.

Top module: `freq_counter_gated`

## Requirements
- R1: While reset is high and in the cycle after it falls, `reading` is all zeros, and `over_range` and `new_reading` are 0.
- R2: Rising edges of `sig_in` are counted only while the gate is open. The gate opens at the tick that enters state 2 and closes at the tick that enters state 12. Edges well inside this 10-tick window are counted exactly, and the count is cleared during state 0.
- R3: `reading` is packed BCD. Decimal digit i sits in bits [4i+3:4i], with the least significant digit in bits [3:0], and every digit is in 0..9.
- R4: `reading` and `over_range` change only on the clock edge where `new_reading` is 1. Between these edges they hold the previous result.
- R5: `new_reading` is high for exactly one cycle per measurement, on the edge that updates `reading`. Successive pulses are 16 ticks apart when the range is steady.
- R6: One tick lasts REF_DIV * 10^r reference cycles, where r is the active range code. A `range_sel` value of NUM_RANGES or more acts as NUM_RANGES-1.
- R7: A change of `range_sel` is taken in only on the tick that enters state 0. A change made while the gate is open leaves the length of the current measurement unchanged.
- R8: If the count passes 10^DIGITS-1 while the gate is open, `over_range` is reported as 1 with that reading, and `reading` shows the count modulo 10^DIGITS. The next measurement without overflow reports 0.
- R9: One low-to-high transition of the synchronized input counts once, however long the input then stays high.
- R10: A measurement with no input transitions reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Conditioned digital input, asynchronous to clk |
| range_sel | input | RW = $clog2(NUM_RANGES) | Gate range code r; tick = REF_DIV*10^r cycles |
| reading | output | 4*DIGITS | Latched BCD result, digit 0 in bits [3:0] |
| over_range | output | 1 | Count overflowed during the latched measurement |
| new_reading | output | 1 | One-cycle pulse when reading is updated |

## Verification
The bench builds the block with REF_DIV=4, NUM_RANGES=3 and DIGITS=3. This gives ticks of 4, 40 and 400 cycles, so a full measurement lasts at most 6400 cycles. With these values the bench can sweep every pulse count from 0 to 10 on the shortest gate. It can also reach the three-digit limit (999 versus 1000 and above) on the longest gate with overflow and its clearing, and it can time the spacing of results for each range code and for an out-of-range code. It also changes the range in the middle of a gate and checks that the gate in progress keeps its old length.

// File: rtl/fc_pkg.sv
package fc_pkg;
  // Sequencer state codes that carry meaning
  localparam logic [3:0] ST_CLEAR = 4'd0;
  localparam logic [3:0] ST_OPEN  = 4'd2;
  localparam logic [3:0] ST_SHUT  = 4'd12;
  localparam logic [3:0] ST_SAVE  = 4'd14;
  localparam logic [3:0] ST_LAST  = 4'd15;
  localparam logic [3:0] BCD_NINE = 4'd9;
endpackage

// File: rtl/fc_timebase.sv
module fc_timebase #(
  parameter int REF_DIV    = 1000,
  parameter int NUM_RANGES = 6,
  parameter int RW         = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] sel,
  output logic          tick
);
  import fc_pkg::*;
  localparam int PW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int ND = NUM_RANGES - 1;

  logic [PW-1:0]         pre;
  logic [NUM_RANGES-1:0] carry;

  always_ff @(posedge clk) begin
    if (rst || carry[0]) pre <= '0;
    else                 pre <= pre + 1'b1;
  end
  assign carry[0] = (pre == PW'(REF_DIV - 1));

  generate
    for (genvar i = 0; i < ND; i++) begin : g_dec
      logic [3:0] dec;
      always_ff @(posedge clk) begin
        if (rst) dec <= '0;
        else if (carry[i]) dec <= (dec == BCD_NINE) ? 4'd0 : dec + 4'd1;
      end
      assign carry[i+1] = carry[i] && (dec == BCD_NINE);
      AST_DECADE_BOUND: assert property (@(posedge clk) disable iff (rst)
        dec <= BCD_NINE); // R6
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= carry[sel];
  end
endmodule

// File: rtl/fc_sequencer.sv
module fc_sequencer #(
  parameter int NUM_RANGES = 6,
  parameter int RW         = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [RW-1:0] range_req,
  output logic [RW-1:0] range_act,
  output logic          clear,
  output logic          gate,
  output logic          save
);
  import fc_pkg::*;
  localparam logic [RW-1:0] TOP_RANGE = RW'(NUM_RANGES - 1);

  logic [3:0]    st;
  logic [RW-1:0] range_ok;
  logic          load_range;

  assign range_ok   = (range_req > TOP_RANGE) ? TOP_RANGE : range_req;
  assign load_range = tick && (st == ST_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_CLEAR;
      range_act <= range_ok;
    end else begin
      if (tick) st <= st + 4'd1;
      if (load_range) range_act <= range_ok;
    end
  end

  assign clear = (st == ST_CLEAR);
  assign gate  = (st >= ST_OPEN) && (st < ST_SHUT);
  assign save  = tick && (st == ST_SAVE - 4'd1);

  AST_GATE_CLEAR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(gate && clear)); // R2
  AST_SAVE_GATE_SHUT: assert property (@(posedge clk) disable iff (rst)
    save |-> !gate); // R2
  AST_RANGE_HELD: assert property (@(posedge clk) disable iff (rst)
    !load_range |=> $stable(range_act)); // R7
  AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    range_act <= TOP_RANGE); // R6
endmodule

// File: rtl/fc_bcd_chain.sv
module fc_bcd_chain #(
  parameter int DIGITS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                inc,
  output logic [4*DIGITS-1:0] value,
  output logic                ovf
);
  import fc_pkg::*;
  logic [DIGITS:0] carry;
  assign carry[0] = inc;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [3:0] d;
      always_ff @(posedge clk) begin
        if (rst || clear) d <= '0;
        else if (carry[i]) d <= (d == BCD_NINE) ? 4'd0 : d + 4'd1;
      end
      assign carry[i+1] = carry[i] && (d == BCD_NINE);
      assign value[4*i +: 4] = d;
      AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        d <= BCD_NINE); // R3
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear)      ovf <= 1'b0;
    else if (carry[DIGITS]) ovf <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clear) |=> ovf); // R8
endmodule

// File: rtl/freq_counter_gated.sv
module freq_counter_gated #(
  parameter int REF_DIV    = 1000,
  parameter int NUM_RANGES = 6,
  parameter int DIGITS     = 7,
  localparam int RW        = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sig_in,
  input  logic [RW-1:0]       range_sel,
  output logic [4*DIGITS-1:0] reading,
  output logic                over_range,
  output logic                new_reading
);
  logic          tick, clear, gate, save;
  logic [RW-1:0] range_act;
  logic          s1, s2, s3, rise;
  logic [4*DIGITS-1:0] cnt;
  logic          cnt_ovf;

  fc_timebase #(.REF_DIV(REF_DIV), .NUM_RANGES(NUM_RANGES), .RW(RW)) u_tb (
    .clk(clk), .rst(rst), .sel(range_act), .tick(tick));

  fc_sequencer #(.NUM_RANGES(NUM_RANGES), .RW(RW)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .range_req(range_sel),
    .range_act(range_act), .clear(clear), .gate(gate), .save(save));

  // two-flop synchronizer plus edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= sig_in; s2 <= s1; s3 <= s2;
    end
  end
  assign rise = s2 && !s3;

  fc_bcd_chain #(.DIGITS(DIGITS)) u_cnt (
    .clk(clk), .rst(rst), .clear(clear), .inc(rise && gate),
    .value(cnt), .ovf(cnt_ovf));

  always_ff @(posedge clk) begin
    if (rst) begin
      reading     <= '0;
      over_range  <= 1'b0;
      new_reading <= 1'b0;
    end else begin
      new_reading <= save;
      if (save) begin
        reading    <= cnt;
        over_range <= cnt_ovf;
      end
    end
  end

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!gate && !clear) |=> $stable(cnt)); // R2
  AST_DISPLAY_HELD: assert property (@(posedge clk) disable iff (rst)
    !save |=> ($stable(reading) && $stable(over_range))); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    new_reading |=> !new_reading); // R5
  AST_ONE_COUNT_PER_RISE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R9
endmodule

// File: tb/sim_freq_counter_gated.sv
module sim_freq_counter_gated;
  localparam int REF_DIV = 4;
  localparam int NR      = 3;
  localparam int D       = 3;
  localparam int RW      = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic [RW-1:0] range_sel = 2'd1;
  logic [4*D-1:0] reading;
  logic over_range, new_reading;

  always #2.5 clk = ~clk;

  freq_counter_gated #(.REF_DIV(REF_DIV), .NUM_RANGES(NR), .DIGITS(D)) u0 (
    .clk(clk), .rst(rst), .sig_in(sig_in), .range_sel(range_sel),
    .reading(reading), .over_range(over_range), .new_reading(new_reading));

  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_strobe = 0, gap = 0;
  int T = 40;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [4*D-1:0] to_bcd(input int v);
    logic [4*D-1:0] r;
    int x;
    x = v;
    for (int i = 0; i < D; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!new_reading);
    gap = cyc - last_strobe;
    last_strobe = cyc;
  endtask

  // assumes the call starts right after a strobe was seen
  task automatic measure(input int n, input int hi, input int lo, input string req);
    logic [4*D-1:0] prev;
    logic prev_ovf;
    int mod;
    mod = 1;
    for (int i = 0; i < D; i++) mod = mod * 10;
    prev = reading;
    prev_ovf = over_range;
    repeat (5 * T) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      sig_in = 1'b1;
      repeat (hi) @(negedge clk);
      sig_in = 1'b0;
      repeat (lo) @(negedge clk);
    end
    check("R4 reading held mid-measurement", int'(reading), int'(prev));
    check("R4 over_range held", int'(over_range), int'(prev_ovf));
    wait_strobe();
    check({req, " reading"}, int'(reading), int'(to_bcd(n % mod)));
    check("R8 over_range", int'(over_range), (n >= mod) ? 1 : 0);
    check("R5 strobe spacing 16 ticks", gap, 16 * T);
    @(negedge clk);
    check("R5 strobe one cycle", int'(new_reading), 0);
  endtask

  task automatic switch_range(input int r, input int t_new);
    range_sel = RW'(r);
    wait_strobe();
    T = t_new;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reading in reset", int'(reading), 0);
    check("R1 over_range in reset", int'(over_range), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reading after reset", int'(reading), 0);
    check("R1 strobe after reset", int'(new_reading), 0);
    wait_strobe();
    check("R10 first idle reading", int'(reading), 0);
    wait_strobe();
    // range 1: tick 40
    measure(0, 1, 1, "R10 no input");
    measure(1, 1, 1, "R2 single pulse");
    measure(9, 1, 1, "R2 nine");
    measure(10, 1, 1, "R3 carry into tens");
    measure(99, 1, 1, "R3 two nines");
    measure(100, 1, 1, "R3 carry into hundreds");
    measure(150, 1, 1, "R2 dense burst");
    measure(3, 20, 20, "R9 wide pulses");
    measure(1, 250, 10, "R9 long high");
    // range 0: exhaustive small counts
    switch_range(0, 4);
    for (int n = 0; n <= 10; n++) measure(n, 1, 1, "R6 range0 sweep");
    // R7: change range during an open gate of range 1
    switch_range(1, 40);
    repeat (5 * T) @(negedge clk);
    for (int k = 0; k < 7; k++) begin
      sig_in = 1'b1; @(negedge clk); sig_in = 1'b0; @(negedge clk);
    end
    range_sel = 2'd2;
    wait_strobe();
    check("R7 gate length kept after mid-gate change", gap, 16 * 40);
    check("R7 reading after mid-gate change", int'(reading), int'(to_bcd(7)));
    wait_strobe();
    wait_strobe();
    check("R6 range2 spacing", gap, 16 * 400);
    T = 400;
    measure(999, 1, 1, "R8 full scale");
    measure(1000, 1, 1, "R8 wrap to zero");
    measure(1234, 1, 1, "R8 wrap remainder");
    measure(5, 1, 1, "R8 overflow cleared");
    // out-of-range code acts as the top range
    switch_range(3, 400);
    wait_strobe();
    check("R6 clamped code spacing", gap, 16 * 400);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule